// File: doc/BRIEF.md
# Phase-Change Memory Asymmetric Write Controller

This block takes cache write-back and pre-set requests and turns them into bit-masked write pulses on a phase-change memory array port. Such cells wear out with every write and clear (write 0) faster than they set (write 1). The block therefore writes only the bits that must change. It runs the short clear phase before the long set phase, and it checks every write by reading the word back.

A pre-set request, issued when a cache line first becomes dirty, drives every bit of the target block to 1 in the background. The block then records that the block is pre-set. A later write-back to such a block skips the initial read and issues a single clear pulse. A write-back to any other block reads the old word, compares it with the new data, and writes only the differing bits.

After each pass a verify read compares the array with the target. If they differ, only the mismatching bits are rewritten, up to a bounded number of retries. Each request ends with a one-cycle done pulse that carries a status code and the block address.

Top module: `pcmw_ctrl`

## Requirements
- R1: After reset, req_ready is 1, done_valid is 0, mem_rd_en and mem_wr_en are 0, and no block is marked pre-set.
- R2: A request is accepted on a cycle with req_valid and req_ready both 1. req_ready stays 0 from the cycle after acceptance through the done cycle. done_valid is high for exactly one cycle per accepted request.
- R3: A write-back (req_op = 0) to a block not marked pre-set first reads the block. It then clears only bits that are 1 in the old word and 0 in the new data, and sets only bits that are 0 in the old word and 1 in the new data. A phase whose mask is empty issues no write pulse.
- R4: A pre-set request (req_op = 1) reads the block and sets to 1 only the bits that read 0. On success it marks the block pre-set.
- R5: A write-back to a block marked pre-set skips the initial read. Its first pass issues one clear pulse with mask equal to the inverted data and no set pulse. Completion removes the pre-set mark.
- R6: Within a pass, the clear pulse (mem_wr_one = 0) comes before the set pulse (mem_wr_one = 1). After a clear pulse there is no memory access for T_CLR cycles. After a set pulse there is none for T_SET cycles.
- R7: Every pass ends with a verify read. On a mismatch, the next pass writes only the mismatching bits.
- R8: At most MAX_RETRY (3) extra passes are made. done_status is 0 when the first verify matched, 1 when a retry was needed and succeeded, and 2 when the last verify still mismatched. done_addr gives the block address.
- R9: A failed request leaves the block unmarked, so a later write-back to it reads first.
- R10: mem_rd_en and mem_wr_en are never both 1. Every access uses the address of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 1 | 0 = write-back, 1 = pre-set to all ones |
| req_addr | input | ADDR_W | Block address |
| req_data | input | DATA_W | Write-back data |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 retried, 2 failed |
| done_addr | output | ADDR_W | Address of the completed request |
| mem_addr | output | ADDR_W | Array block address |
| mem_rd_en | output | 1 | Array read; data is returned the next cycle |
| mem_rdata | input | DATA_W | Array read data |
| mem_wr_en | output | 1 | Array write pulse |
| mem_wr_one | output | 1 | Pulse sets masked bits (1) or clears them (0) |
| mem_wmask | output | DATA_W | Bits affected by the write pulse |

## Verification
The bound checker enforces the following on every cycle:
- read and write are never issued together, and no write pulse carries an empty mask;
- the clear and set settle windows hold before the next access;
- done is a single-cycle pulse with a legal status code;
- an accepted write-back to a pre-set block is never followed by a read.

Only the bench's scenarios can show the rest, using a behavioural array that has one flaky bit and one stuck-at-0 bit. These cover the exact counts of reads, pulses and written bits per request, the retried and failed outcomes, the array contents after completion, and that a failed pre-set sends the next write-back back to read-compare-write.

// File: rtl/pcmw_pkg.sv
package pcmw_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_RETRIED = 2'd1,
        ST_FAILED  = 2'd2
    } wr_status_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_READ,
        F_CMP,
        F_CLR,
        F_SET,
        F_VREAD,
        F_VCHK,
        F_DONE
    } fsm_e;

    localparam logic OP_WB     = 1'b0;
    localparam logic OP_PRESET = 1'b1;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pcmw_diff.sv
// Splits the difference between the current and target words into
// bits that must be cleared and bits that must be set.
module pcmw_diff #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] tgt,
    output logic [DATA_W-1:0] clr,
    output logic [DATA_W-1:0] set,
    output logic              any
);
    assign clr = cur & ~tgt;
    assign set = ~cur & tgt;
    assign any = |(cur ^ tgt);
endmodule

// File: rtl/pcmw_preset_map.sv
// One flag per block: set while the block is known to hold all ones.
module pcmw_preset_map #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              hit
);
    localparam int NBLK = 1 << ADDR_W;

    logic [NBLK-1:0] flag_q;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[b] <= 1'b0;
            end else if (wr_addr == ADDR_W'(b)) begin
                if (set_en) begin
                    flag_q[b] <= 1'b1;
                end else if (clr_en) begin
                    flag_q[b] <= 1'b0;
                end
            end
        end
    end

    assign hit = flag_q[rd_addr];
endmodule

// File: rtl/pcmw_phase_timer.sv
// Counts cycles spent in a write phase; restarted on each state change.
module pcmw_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             first,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign first   = (cnt_q == '0);
    assign expired = (cnt_q == limit);
endmodule

// File: rtl/pcmw_ctrl.sv
module pcmw_ctrl
    import pcmw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int T_CLR     = 3,
    parameter int T_SET     = 8,
    parameter int MAX_RETRY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done_valid,
    output logic [1:0]        done_status,
    output logic [ADDR_W-1:0] done_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr_en,
    output logic              mem_wr_one,
    output logic [DATA_W-1:0] mem_wmask
);
    localparam int CNT_W   = $clog2(imax(T_CLR, T_SET) + 1);
    localparam int RETRY_W = $clog2(MAX_RETRY + 1);

    typedef struct packed {
        logic [DATA_W-1:0] clr;
        logic [DATA_W-1:0] set;
    } mask_pair_t;

    fsm_e              state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] tgt_q;
    mask_pair_t        mask_q;
    mask_pair_t        diff;
    logic              diff_any;
    logic              op_q;
    logic [RETRY_W-1:0] retry_q;
    wr_status_e        status_q;

    logic              pre_hit_req;
    logic              map_set, map_clr;
    logic              tmr_clear, tmr_first, tmr_exp;
    logic [CNT_W-1:0]  tmr_limit;
    logic              retry_spent;

    pcmw_diff #(.DATA_W(DATA_W)) u_diff (
        .cur (mem_rdata),
        .tgt (tgt_q),
        .clr (diff.clr),
        .set (diff.set),
        .any (diff_any)
    );

    pcmw_preset_map #(.ADDR_W(ADDR_W)) u_map (
        .clk     (clk),
        .rst     (rst),
        .set_en  (map_set),
        .clr_en  (map_clr),
        .wr_addr (addr_q),
        .rd_addr (req_addr),
        .hit     (pre_hit_req)
    );

    pcmw_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (tmr_clear),
        .limit   (tmr_limit),
        .first   (tmr_first),
        .expired (tmr_exp)
    );

    assign retry_spent = (retry_q == RETRY_W'(MAX_RETRY));
    assign tmr_clear   = (state_d != state_q);

    always_comb begin
        state_d    = state_q;
        mem_rd_en  = 1'b0;
        mem_wr_en  = 1'b0;
        mem_wr_one = 1'b0;
        mem_wmask  = '0;
        tmr_limit  = '0;
        map_set    = 1'b0;
        map_clr    = 1'b0;
        unique case (state_q)
            F_IDLE: begin
                if (req_valid) begin
                    state_d = (req_op == OP_WB && pre_hit_req) ? F_CLR : F_READ;
                end
            end
            F_READ: begin
                mem_rd_en = 1'b1;
                state_d   = F_CMP;
            end
            F_CMP: state_d = F_CLR;
            F_CLR: begin
                // short clear phase first
                tmr_limit = CNT_W'(T_CLR - 1);
                mem_wr_en = (mask_q.clr != '0) && tmr_first;
                if (mem_wr_en) mem_wmask = mask_q.clr;
                if (mask_q.clr == '0 || tmr_exp) state_d = F_SET;
            end
            F_SET: begin
                tmr_limit  = CNT_W'(T_SET - 1);
                mem_wr_en  = (mask_q.set != '0) && tmr_first;
                mem_wr_one = 1'b1;
                if (mem_wr_en) mem_wmask = mask_q.set;
                if (mask_q.set == '0 || tmr_exp) state_d = F_VREAD;
            end
            F_VREAD: begin
                mem_rd_en = 1'b1;
                state_d   = F_VCHK;
            end
            F_VCHK: begin
                if (!diff_any) begin
                    state_d = F_DONE;
                    if (op_q == OP_PRESET) map_set = 1'b1;
                    else                   map_clr = 1'b1;
                end else if (retry_spent) begin
                    state_d = F_DONE;
                    map_clr = 1'b1;
                end else begin
                    state_d = F_CLR;
                end
            end
            F_DONE:  state_d = F_IDLE;
            default: state_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= F_IDLE;
            addr_q   <= '0;
            tgt_q    <= '0;
            mask_q   <= '0;
            op_q     <= OP_WB;
            retry_q  <= '0;
            status_q <= ST_OK;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                F_IDLE: begin
                    if (req_valid) begin
                        addr_q     <= req_addr;
                        op_q       <= req_op;
                        tgt_q      <= (req_op == OP_PRESET) ? '1 : req_data;
                        retry_q    <= '0;
                        // used only on the pre-set fast path; a read overwrites it
                        mask_q.clr <= ~req_data;
                        mask_q.set <= '0;
                    end
                end
                F_CMP: mask_q <= diff;
                F_VCHK: begin
                    if (!diff_any) begin
                        status_q <= (retry_q == '0) ? ST_OK : ST_RETRIED;
                    end else if (retry_spent) begin
                        status_q <= ST_FAILED;
                    end else begin
                        retry_q <= retry_q + 1'b1;
                        mask_q  <= diff;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready   = (state_q == F_IDLE);
    assign done_valid  = (state_q == F_DONE);
    assign done_status = status_q;
    assign done_addr   = addr_q;
    assign mem_addr    = addr_q;

endmodule

// File: rtl/pcmw_ctrl_chk.sv
module pcmw_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int T_CLR  = 3,
    parameter int T_SET  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_op,
    input logic              pre_hit,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              mem_wr_one,
    input logic [DATA_W-1:0] mem_wmask,
    input logic              done_valid,
    input logic [1:0]        done_status
);
    logic [7:0] gap_q;
    logic       seen_w_q, last_one_q;
    logic       access;

    assign access = mem_rd_en || mem_wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q      <= '0;
            seen_w_q   <= 1'b0;
            last_one_q <= 1'b0;
        end else if (mem_wr_en) begin
            gap_q      <= 8'd1;
            seen_w_q   <= 1'b1;
            last_one_q <= mem_wr_one;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    a_r10_exclusive_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    a_r3_no_empty_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wmask != '0));

    a_r6_clear_settle: assert property (@(posedge clk) disable iff (rst)
        (access && seen_w_q && !last_one_q) |-> (int'(gap_q) >= T_CLR));

    a_r6_set_settle: assert property (@(posedge clk) disable iff (rst)
        (access && seen_w_q && last_one_q) |-> (int'(gap_q) >= T_SET));

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    a_r2_busy_at_done: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> !req_ready);

    a_r8_legal_status: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_status != 2'd3));

    a_r5_preset_no_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_op && pre_hit) |=> !mem_rd_en);

endmodule

bind pcmw_ctrl pcmw_ctrl_chk #(
    .DATA_W (DATA_W),
    .T_CLR  (T_CLR),
    .T_SET  (T_SET)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .pre_hit     (pre_hit_req),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_one  (mem_wr_one),
    .mem_wmask   (mem_wmask),
    .done_valid  (done_valid),
    .done_status (done_status)
);

// File: tb/pcmw_ctrl_tb.sv
`timescale 1ns/1ps
module pcmw_ctrl_tb;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NBLK = 1 << AW;
    localparam int TC = 3;
    localparam int TS = 8;
    localparam logic [1:0] S_OK = 2'd0, S_RETRY = 2'd1, S_FAIL = 2'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_op = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, done_valid, mem_rd_en, mem_wr_en, mem_wr_one;
    logic [1:0] done_status;
    logic [AW-1:0] done_addr, mem_addr;
    logic [DW-1:0] mem_rdata, mem_wmask;

    always #10 clk = ~clk;

    pcmw_ctrl #(.DATA_W(DW), .ADDR_W(AW), .T_CLR(TC), .T_SET(TS), .MAX_RETRY(3)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .done_valid(done_valid), .done_status(done_status), .done_addr(done_addr),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wr_one(mem_wr_one), .mem_wmask(mem_wmask)
    );

    // behavioural array with one stuck-at-0 block bit and one flaky bit
    logic [DW-1:0] mem [NBLK];
    logic [DW-1:0] stuck0 [NBLK];
    logic [DW-1:0] flaky_mask = '0;
    int flaky_budget = 0;
    int flaky_used = 0;

    always @(posedge clk) begin
        logic [DW-1:0] m;
        if (rst) begin
            for (int i = 0; i < NBLK; i++)
                mem[i] <= (32'h1234_5678 ^ (i * 32'h0101_0101)) & ~stuck0[i];
            mem_rdata <= '0;
        end else begin
            if (mem_rd_en) mem_rdata <= mem[mem_addr];
            if (mem_wr_en) begin
                m = mem_wmask;
                if ((m & flaky_mask) != '0 && flaky_used < flaky_budget) begin
                    m = m & ~flaky_mask;
                    flaky_used = flaky_used + 1;
                end
                if (mem_wr_one) mem[mem_addr] <= mem[mem_addr] | (m & ~stuck0[mem_addr]);
                else            mem[mem_addr] <= mem[mem_addr] & ~m;
            end
        end
    end

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    status;
        int            reads;
        int            writes;
        int            bits;
        logic          chk_data;
        logic [DW-1:0] data;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    logic  bpre [NBLK];
    int n_checks = 0, n_fail = 0, issued = 0, n_done = 0;
    int excl_bad = 0, addr_bad = 0, order_bad = 0, busy_bad = 0, pulse_bad = 0;
    int min_clr_gap = 1000, min_set_gap = 1000;

    task automatic chk(input string r, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    // mode 0: fault-free expectation; 1: flaky bit costs two retries; 2: stuck bit fails
    task automatic issue(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int mode, input string tag);
        exp_t e;
        logic [DW-1:0] old, tgt, c, s;
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        do @(negedge clk); while (!req_ready);
        old = mem[a];
        tgt = op ? '1 : d;
        if (!op && bpre[a]) begin
            e.reads = 1; c = ~d; s = '0;
        end else begin
            e.reads = 2; c = old & ~tgt; s = ~old & tgt;
        end
        e.writes = int'(c != '0) + int'(s != '0);
        e.bits = $countones(c) + $countones(s);
        e.status = S_OK; e.addr = a; e.data = tgt; e.chk_data = 1'b1;
        if (mode == 1) begin
            e.status = S_RETRY; e.reads += 2; e.writes += 2; e.bits += 2;
        end else if (mode == 2) begin
            e.status = S_FAIL; e.reads += 3; e.writes = -1; e.bits = -1; e.chk_data = 1'b0;
        end
        bpre[a] = op && (e.status != S_FAIL);
        q.push_back(e); tq.push_back(tag); issued++;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic monitor();
        int cyc = 0, wcyc = 0, n_rd = 0, n_wr = 0, n_bits = 0;
        bit have_w = 0, wone = 0, set_since_rd = 0, after_acc = 0, prev_done = 0;
        exp_t e;
        string t;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) continue;
            if (mem_rd_en && mem_wr_en) excl_bad++;
            if ((mem_rd_en || mem_wr_en) && q.size() > 0 && mem_addr !== q[0].addr) addr_bad++;
            if ((mem_rd_en || mem_wr_en) && have_w) begin
                if (wone) min_set_gap = (cyc - wcyc < min_set_gap) ? cyc - wcyc : min_set_gap;
                else      min_clr_gap = (cyc - wcyc < min_clr_gap) ? cyc - wcyc : min_clr_gap;
            end
            if (mem_rd_en) begin n_rd++; set_since_rd = 0; end
            if (mem_wr_en) begin
                n_wr++;
                n_bits += $countones(mem_wmask);
                if (!mem_wr_one && set_since_rd) order_bad++;
                if (mem_wr_one) set_since_rd = 1;
                have_w = 1; wcyc = cyc; wone = mem_wr_one;
            end
            if (after_acc && req_ready) busy_bad++;
            after_acc = req_valid && req_ready;
            if (prev_done && done_valid) pulse_bad++;
            prev_done = done_valid;
            if (done_valid) begin
                n_done++;
                if (req_ready) busy_bad++;
                if (q.size() == 0) begin
                    chk("R2", "unexpected done", 1, 0);
                end else begin
                    e = q.pop_front(); t = tq.pop_front();
                    chk((e.status == S_FAIL) ? "R8" : t, "status", done_status, e.status);
                    chk("R8", "done_addr", done_addr, e.addr);
                    chk(t, "reads", n_rd, e.reads);
                    if (e.writes >= 0) chk(t, "write pulses", n_wr, e.writes);
                    if (e.bits >= 0) chk((e.status == S_RETRY) ? "R7" : t, "bits written", n_bits, e.bits);
                    if (e.chk_data) chk(t, "array word", mem[e.addr], e.data);
                end
                n_rd = 0; n_wr = 0; n_bits = 0; have_w = 0; set_since_rd = 0;
            end
        end
    endtask

    initial begin
        logic [DW-1:0] d7, cand;
        for (int i = 0; i < NBLK; i++) begin
            stuck0[i] = '0; bpre[i] = 1'b0;
        end
        stuck0[9] = 32'h0000_0001;
        fork
            monitor();
            begin
                repeat (50000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "req_ready in reset", req_ready, 1);
        chk("R1", "done_valid in reset", done_valid, 0);
        chk("R1", "mem enables in reset", {mem_rd_en, mem_wr_en}, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "req_ready after reset", req_ready, 1);

        // R3 read-compare-write; R1 no block pre-set, so two reads
        issue(1'b0, 4'd2, 32'hA5A5_0FF0, 0, "R3");
        issue(1'b0, 4'd2, 32'hA5A5_0FF0, 0, "R3");   // no difference: no pulse
        // R4 pre-set, then R5 fast write-back, then plain again
        issue(1'b1, 4'd5, '0, 0, "R4");
        issue(1'b0, 4'd5, 32'h0F0F_3C3C, 0, "R5");
        issue(1'b0, 4'd5, 32'hFFFF_0000, 0, "R5");
        // R2 back-to-back requests
        issue(1'b0, 4'd0, 32'hDEAD_BEEF, 0, "R2");
        issue(1'b0, 4'd1, 32'h0000_0000, 0, "R2");
        issue(1'b1, 4'd3, '0, 0, "R2");
        issue(1'b0, 4'd3, 32'hFFFF_FFFF, 0, "R2");

        // R7 flaky bit: two failed attempts on one set bit
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        d7 = mem[7] ^ 32'h0000_FFFF;
        cand = ~mem[7] & d7;
        for (int b = DW - 1; b >= 0; b--) if (cand[b]) flaky_mask = DW'(1) << b;
        flaky_budget = flaky_used + 2;
        issue(1'b0, 4'd7, d7, 1, "R7");

        // R8 stuck bit: write-back and pre-set both fail; R9 next write reads first
        issue(1'b0, 4'd9, 32'h0000_00FF, 2, "R8");
        issue(1'b1, 4'd9, '0, 2, "R9");
        issue(1'b0, 4'd9, 32'h1234_5670, 0, "R9");

        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R2", "done count", n_done, issued);
        chk("R2", "ready low while busy", busy_bad, 0);
        chk("R2", "done pulse width", pulse_bad, 0);
        chk("R6", "clear before set", order_bad, 0);
        chk("R6", "clear settle ok", int'(min_clr_gap >= TC), 1);
        chk("R6", "set settle ok", int'(min_set_gap >= TS), 1);
        chk("R10", "read and write together", excl_bad, 0);
        chk("R10", "access address", addr_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule